// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that gives a small 8-bit-data, 16-bit-address CPU its interrupt support. It watches a request line that comes from a latch outside the block (the device sets it, the handler's software clears it). It acts on that line only when the instruction decoder signals the end of an instruction and the interrupt-enable bit of the status register is set. It does not clear the latch itself.

Once it accepts a request, the sequencer drives the memory bus for several cycles. It saves the program counter and the status register onto a stack held in one fixed memory page. It then reads the handler address as two bytes from a fixed vector location and loads it into the program counter, together with the saved status with its interrupt-enable bit cleared. When the decoder issues a return command, the sequencer reads the saved bytes back in the reverse order and restores both registers. The stack pointer itself lives in the CPU: the sequencer reads it when a sequence starts and sends each new value back through an update strobe. While it is active, `busy` tells the CPU to stall.

Top module: `intr_seq`

## Requirements
- R1: An entry sequence starts only from idle, and only in a cycle where `instr_end`, `irq_pending` and `status_in[7]` (the interrupt-enable bit) are all high; `irq_ack` is high for exactly one cycle, the first cycle of that entry.
- R2: On entry the block makes three stack writes in consecutive cycles: PC bits 15:8, then PC bits 7:0, then the status byte. Each write goes to address {0x01, sp-1}, where sp is the value before that write, and `sp_we`/`sp_wdata` report the decremented value in the same cycle.
- R3: After the writes, the block reads the byte at 0xFFFE (the low byte of the handler address) and then the byte at 0xFFFF (the high byte), and loads the 16-bit result through `pc_we`/`pc_wdata`.
- R4: On entry the status loaded through `st_we`/`st_wdata` equals the saved status with bit 7 cleared; all other bits are kept.
- R5: A return command makes three stack reads: status, then PC bits 7:0, then PC bits 15:8. Each read is at {0x01, sp}, after which sp is incremented. The restored PC and status equal the bytes read, with no change to any bit.
- R6: `done` is high for exactly one cycle: 6 cycles after the clock edge that accepts an entry, and 4 cycles after the edge that accepts a return. The PC and status loads happen in that same cycle, and the block is idle in the next cycle.
- R7: While the block is busy, `instr_end`, `irq_pending` and `rti_cmd` have no effect on the bus traffic or on the values loaded.
- R8: When `rti_cmd` arrives in the same idle cycle as an acceptable interrupt request, the return runs and the request is not taken in that cycle; no stack write happens.
- R9: The stack pointer wraps modulo 256 within the stack page in both directions.
- R10: After reset the block is idle, with `mem_req`, `pc_we`, `st_we`, `sp_we`, `done`, `irq_ack` and `busy` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_end | input | 1 | Instruction boundary strobe from the decoder |
| irq_pending | input | 1 | Output of the external request latch |
| rti_cmd | input | 1 | Return-from-interrupt command from the decoder |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status register (bit 7 = interrupt enable) |
| sp_in | input | 8 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid in the cycle of the read request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | 8 | New stack pointer value |
| pc_we | output | 1 | Program counter load strobe |
| pc_wdata | output | 16 | Program counter load value |
| st_we | output | 1 | Status register load strobe |
| st_wdata | output | 8 | Status register load value |
| irq_ack | output | 1 | One-cycle acknowledge at the start of entry |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequencer active; the CPU should stall |

## Verification
The bench checks the exact stack addresses and the byte order of the three pushes. A design that swapped the PC halves, or that decremented the pointer after the write, would leave a different byte at each address and restore a wrong PC on return. It starts a push frame near address 0x01 so the pointer wraps through 0x00 to 0xFF, which catches arithmetic that leaves the page. It raises a request with the enable bit clear, and another without an instruction boundary, and expects no bus activity in either case; a design that ignored either condition would start an entry there. It also issues commands in the middle of a sequence, and a return in the same cycle as a request, where a wrong priority would write a second frame over the stack.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SP_W   = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_PUSH_ST,
        S_VEC_LO,
        S_VEC_HI,
        S_POP_ST,
        S_POP_LO,
        S_POP_HI,
        S_FIN
    } seq_state_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sp_we;
        logic [SP_W-1:0]   sp_next;
    } bus_op_t;

    function automatic logic is_push(seq_state_e s);
        return (s == S_PUSH_HI) || (s == S_PUSH_LO) || (s == S_PUSH_ST);
    endfunction

    function automatic logic is_pop(seq_state_e s);
        return (s == S_POP_ST) || (s == S_POP_LO) || (s == S_POP_HI);
    endfunction

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
    import intr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_end,
    input  logic       irq_pending,
    input  logic       ie,
    input  logic       rti_cmd,
    output seq_state_e state,
    output logic       entering,
    output logic       launch
);

    seq_state_e state_d;
    logic       take_irq;

    assign take_irq = instr_end && irq_pending && ie;
    assign launch   = (state == S_IDLE) && (rti_cmd || take_irq);

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE: begin
                if (rti_cmd)       state_d = S_POP_ST;
                else if (take_irq) state_d = S_PUSH_HI;
            end
            S_PUSH_HI: state_d = S_PUSH_LO;
            S_PUSH_LO: state_d = S_PUSH_ST;
            S_PUSH_ST: state_d = S_VEC_LO;
            S_VEC_LO:  state_d = S_VEC_HI;
            S_VEC_HI:  state_d = S_FIN;
            S_POP_ST:  state_d = S_POP_LO;
            S_POP_LO:  state_d = S_POP_HI;
            S_POP_HI:  state_d = S_FIN;
            S_FIN:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            entering <= 1'b0;
        end else begin
            state <= state_d;
            if (launch) entering <= !rti_cmd;
        end
    end

    // R1: an entry may only begin after a boundary with an enabled, pending request
    assert_entry_gated_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_PUSH_HI) |-> $past(instr_end && irq_pending && ie && !rti_cmd));

    // R6: the completion state lasts one cycle and leads back to idle
    assert_fin_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (state == S_FIN) |=> (state == S_IDLE));

    // R8: a return command in idle never leads into a push
    assert_rti_priority_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(state == S_IDLE) && $past(rti_cmd)) |-> (state == S_POP_ST));

endmodule

// File: rtl/intr_seq_regs.sv
module intr_seq_regs
    import intr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              launch,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [SP_W-1:0]   sp_q,
    output logic [ADDR_W-1:0] pc_save,
    output logic [DATA_W-1:0] st_save,
    output logic [DATA_W-1:0] byte_lo,
    output logic [DATA_W-1:0] byte_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= '0;
            pc_save <= '0;
            st_save <= '0;
            byte_lo <= '0;
            byte_hi <= '0;
        end else begin
            if (launch) begin
                sp_q    <= sp_in;
                pc_save <= pc_in;
                st_save <= status_in;
            end
            if (is_push(state)) sp_q <= sp_q - 1'b1;
            if (is_pop(state))  sp_q <= sp_q + 1'b1;
            unique case (state)
                S_VEC_LO, S_POP_LO: byte_lo <= mem_rdata;
                S_VEC_HI, S_POP_HI: byte_hi <= mem_rdata;
                S_POP_ST:           st_save <= mem_rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/intr_seq_bus.sv
module intr_seq_bus
    import intr_seq_pkg::*;
#(
    parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01,
    parameter logic [ADDR_W-1:0]      VEC_ADDR   = 16'hFFFE
) (
    input  seq_state_e        state,
    input  logic [SP_W-1:0]   sp_q,
    input  logic [ADDR_W-1:0] pc_save,
    input  logic [DATA_W-1:0] st_save,
    output bus_op_t           op
);

    logic [SP_W-1:0] sp_dec;
    logic [SP_W-1:0] sp_inc;

    assign sp_dec = sp_q - 1'b1;
    assign sp_inc = sp_q + 1'b1;

    always_comb begin
        op = '0;
        if (is_push(state)) begin
            op.req     = 1'b1;
            op.we      = 1'b1;
            op.addr    = {STACK_PAGE, sp_dec};
            op.sp_we   = 1'b1;
            op.sp_next = sp_dec;
        end
        if (is_pop(state)) begin
            op.req     = 1'b1;
            op.addr    = {STACK_PAGE, sp_q};
            op.sp_we   = 1'b1;
            op.sp_next = sp_inc;
        end
        unique case (state)
            S_PUSH_HI: op.wdata = pc_save[ADDR_W-1 -: DATA_W];
            S_PUSH_LO: op.wdata = pc_save[DATA_W-1:0];
            S_PUSH_ST: op.wdata = st_save;
            S_VEC_LO: begin
                op.req  = 1'b1;
                op.addr = VEC_ADDR;
            end
            S_VEC_HI: begin
                op.req  = 1'b1;
                op.addr = VEC_ADDR + 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01,
    parameter logic [ADDR_W-1:0]      VEC_ADDR   = 16'hFFFE,
    parameter int                     IE_BIT     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_end,
    input  logic              irq_pending,
    input  logic              rti_cmd,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sp_we,
    output logic [SP_W-1:0]   sp_wdata,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_wdata,
    output logic              st_we,
    output logic [DATA_W-1:0] st_wdata,
    output logic              irq_ack,
    output logic              done,
    output logic              busy
);

    localparam logic [DATA_W-1:0] IE_MASK = DATA_W'(1) << IE_BIT;

    seq_state_e        state;
    logic              entering;
    logic              launch;
    logic [SP_W-1:0]   sp_q;
    logic [ADDR_W-1:0] pc_save;
    logic [DATA_W-1:0] st_save;
    logic [DATA_W-1:0] byte_lo;
    logic [DATA_W-1:0] byte_hi;
    bus_op_t           op;

    intr_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .instr_end  (instr_end),
        .irq_pending(irq_pending),
        .ie         (status_in[IE_BIT]),
        .rti_cmd    (rti_cmd),
        .state      (state),
        .entering   (entering),
        .launch     (launch)
    );

    intr_seq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .launch   (launch),
        .pc_in    (pc_in),
        .status_in(status_in),
        .sp_in    (sp_in),
        .mem_rdata(mem_rdata),
        .sp_q     (sp_q),
        .pc_save  (pc_save),
        .st_save  (st_save),
        .byte_lo  (byte_lo),
        .byte_hi  (byte_hi)
    );

    intr_seq_bus #(
        .STACK_PAGE(STACK_PAGE),
        .VEC_ADDR  (VEC_ADDR)
    ) u_bus (
        .state  (state),
        .sp_q   (sp_q),
        .pc_save(pc_save),
        .st_save(st_save),
        .op     (op)
    );

    assign mem_req   = op.req;
    assign mem_we    = op.we;
    assign mem_addr  = op.addr;
    assign mem_wdata = op.wdata;
    assign sp_we     = op.sp_we;
    assign sp_wdata  = op.sp_next;

    assign done      = (state == S_FIN);
    assign pc_we     = done;
    assign st_we     = done;
    assign pc_wdata  = {byte_hi, byte_lo};
    assign st_wdata  = entering ? (st_save & ~IE_MASK) : st_save;
    assign irq_ack   = (state == S_PUSH_HI);
    assign busy      = (state != S_IDLE);

    // R2: every write lands in the stack page at the freshly decremented pointer
    assert_push_addr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && sp_we && mem_addr == {STACK_PAGE, sp_wdata}));

    // R4: an entry never loads a status with interrupts enabled
    assert_entry_ie_off_R4: assert property (@(posedge clk) disable iff (rst)
        (st_we && entering) |-> !st_wdata[IE_BIT]);

    // R6: completion is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: no bus or register traffic while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_req || pc_we || st_we || sp_we || irq_ack));

endmodule

// File: tb/intr_seq_bench.sv
module intr_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_end = 1'b0;
    logic        irq_pending = 1'b0;
    logic        rti_cmd = 1'b0;
    logic [15:0] cpu_pc;
    logic [7:0]  cpu_st;
    logic [7:0]  cpu_sp;
    logic [7:0]  mem_rdata;
    logic        mem_req, mem_we, sp_we, pc_we, st_we, irq_ack, done, busy;
    logic [15:0] mem_addr, pc_wdata;
    logic [7:0]  mem_wdata, sp_wdata, st_wdata;

    logic [7:0]  stk [0:255];
    logic [7:0]  vec_lo, vec_hi;
    logic        ld = 1'b0;
    logic [15:0] ld_pc;
    logic [7:0]  ld_st, ld_sp;
    int          wr_cnt = 0;
    int          ack_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_seq u_intr_seq (
        .clk(clk), .rst(rst), .instr_end(instr_end), .irq_pending(irq_pending),
        .rti_cmd(rti_cmd), .pc_in(cpu_pc), .status_in(cpu_st), .sp_in(cpu_sp),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_we(sp_we),
        .sp_wdata(sp_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata), .st_we(st_we),
        .st_wdata(st_wdata), .irq_ack(irq_ack), .done(done), .busy(busy)
    );

    // memory model: combinational read, write at the edge
    always_comb begin
        if (mem_addr == 16'hFFFE)        mem_rdata = vec_lo;
        else if (mem_addr == 16'hFFFF)   mem_rdata = vec_hi;
        else if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else                              mem_rdata = 8'h00;
    end

    // CPU register model
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
        end
        if (irq_ack) ack_cnt <= ack_cnt + 1;
        if (ld) begin
            cpu_pc <= ld_pc;
            cpu_st <= ld_st;
            cpu_sp <= ld_sp;
        end else begin
            if (pc_we) cpu_pc <= pc_wdata;
            if (st_we) cpu_st <= st_wdata;
            if (sp_we) cpu_sp <= sp_wdata;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_cpu(input logic [15:0] pc, input logic [7:0] st,
                            input logic [7:0] sp);
        @(negedge clk);
        ld = 1'b1; ld_pc = pc; ld_st = st; ld_sp = sp;
        @(negedge clk);
        ld = 1'b0;
    endtask

    // entry from pc/st/sp to vector v; noisy drives commands mid-sequence
    task automatic run_entry(input logic [15:0] pc, input logic [7:0] st,
                             input logic [7:0] sp, input logic [15:0] v,
                             input logic noisy);
        int a0, w0;
        load_cpu(pc, st, sp);
        vec_lo = v[7:0]; vec_hi = v[15:8];
        a0 = ack_cnt; w0 = wr_cnt;
        instr_end = 1'b1; irq_pending = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            if (noisy && (i == 2 || i == 3)) begin
                rti_cmd = 1'b1; instr_end = 1'b1;
            end else begin
                rti_cmd = 1'b0; instr_end = 1'b0;
            end
            if (i == 4) chk("R3", "vector low read addr", {mem_req, mem_we, mem_addr}, {2'b10, 16'hFFFE});
            if (i == 5) begin
                chk("R3", "vector high read addr", {mem_req, mem_we, mem_addr}, {2'b10, 16'hFFFF});
                chk("R6", "done early", done, 1'b0);
            end
            if (i == 6) chk("R6", "done at cycle 6", {done, pc_we, st_we}, 3'b111);
            if (i < 6) @(negedge clk);
        end
        irq_pending = 1'b0; rti_cmd = 1'b0; instr_end = 1'b0;
        @(negedge clk);
        chk("R6", "idle after done", {busy, done}, 2'b00);
        chk("R2", "pc high pushed", stk[8'(sp - 8'd1)], pc[15:8]);
        chk("R2", "pc low pushed", stk[8'(sp - 8'd2)], pc[7:0]);
        chk("R2", "status pushed", stk[8'(sp - 8'd3)], st);
        chk("R9", "sp after push", cpu_sp, 8'(sp - 8'd3));
        chk("R3", "pc loaded from vector", cpu_pc, v);
        chk("R4", "status ie cleared", cpu_st, st & 8'h7F);
        chk("R1", "ack count", ack_cnt - a0, 1);
        chk("R7", "write count", wr_cnt - w0, 3);
    endtask

    task automatic run_return(input logic [15:0] exp_pc, input logic [7:0] exp_st,
                              input logic [7:0] exp_sp);
        int w0;
        w0 = wr_cnt;
        @(negedge clk);
        rti_cmd = 1'b1;
        @(negedge clk);
        rti_cmd = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            if (i == 3) chk("R6", "return done early", done, 1'b0);
            if (i == 4) chk("R6", "return done at 4", {done, pc_we, st_we}, 3'b111);
            if (i < 4) @(negedge clk);
        end
        @(negedge clk);
        chk("R5", "pc restored", cpu_pc, exp_pc);
        chk("R5", "status restored", cpu_st, exp_st);
        chk("R9", "sp restored", cpu_sp, exp_sp);
        chk("R5", "no writes on return", wr_cnt - w0, 0);
    endtask

    task automatic t_reset();
        chk("R10", "reset outputs", {mem_req, pc_we, st_we, sp_we, done, irq_ack, busy}, 7'b0);
    endtask

    task automatic t_no_ie();
        int w0;
        load_cpu(16'h2222, 8'h05, 8'hF0);
        w0 = wr_cnt;
        instr_end = 1'b1; irq_pending = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "no entry with ie clear", {busy, mem_req}, 2'b00);
        end
        instr_end = 1'b0; irq_pending = 1'b0;
        chk("R1", "no writes with ie clear", wr_cnt - w0, 0);
    endtask

    task automatic t_no_boundary();
        load_cpu(16'h3333, 8'h85, 8'hF0);
        irq_pending = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "no entry off boundary", {busy, mem_req}, 2'b00);
        end
        irq_pending = 1'b0;
    endtask

    task automatic t_priority();
        int w0;
        run_entry(16'h4321, 8'h81, 8'hC0, 16'h9000, 1'b0);
        load_cpu(16'h9005, 8'h80, 8'hBD);
        w0 = wr_cnt;
        rti_cmd = 1'b1; instr_end = 1'b1; irq_pending = 1'b1;
        @(negedge clk);
        rti_cmd = 1'b0; instr_end = 1'b0; irq_pending = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8", "rti wins pc", cpu_pc, 16'h4321);
        chk("R8", "no frame written", wr_cnt - w0, 0);
        chk("R8", "sp after rti", cpu_sp, 8'hC0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        vec_lo = 8'h00; vec_hi = 8'h00;
        ld_pc = '0; ld_st = '0; ld_sp = '0;
        cpu_pc = '0; cpu_st = '0; cpu_sp = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_entry(16'h1234, 8'h85, 8'hFF, 16'h5678, 1'b0);
        run_return(16'h1234, 8'h85, 8'hFF);
        t_no_ie();
        t_no_boundary();
        run_entry(16'hABCD, 8'h80, 8'h01, 16'h0F0E, 1'b0);   // R9 wrap
        run_return(16'hABCD, 8'h80, 8'h01);
        run_entry(16'h0A0B, 8'hC3, 8'h80, 16'h7766, 1'b1);   // R7 noise
        run_return(16'h0A0B, 8'hC3, 8'h80);
        t_priority();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule